// File: doc/BRIEF.md
# Serial Command Decoder for a Digital Potentiometer

This block is the serial slave in front of a digital potentiometer. A host addresses it with SPI mode 0 frames: a two-byte header that carries a fixed device code, an address bit, an opcode and a register select, optionally followed by two data bytes. The block keeps a 10-bit wiper setting and four 10-bit data registers. It moves values between them, returns any of them on MISO, and reports a save-in-progress flag that the host can poll.

All SPI pins are brought into the system clock domain through two-flop synchronisers and edge detectors. The SPI clock must therefore be much slower than `clk`; at least six `clk` periods per SCK phase is assumed. A frame only takes effect when chip select rises after exactly the number of SCK rising edges that its opcode calls for. The effect lands on the third `clk` rising edge after the rise of `spi_cs_n`. Any write to a data register models a nonvolatile save: the busy flag stays set for `SAVE_CYCLES` clock cycles, and every state-changing command that commits during that time is dropped.

Top module: `spipot_ctrl`

## Requirements
- R1: After reset, `wiper_pos` is `WIPER_INIT` (0), all four data registers read 0, `save_busy` is 0 and `spi_miso_oe` is 0.
- R2: Header bits 15..12 (first bit shifted is bit 15) must equal 4'b0101 and header bit 9 must equal `addr_sel`. Otherwise the frame changes no state and `spi_miso_oe` stays 0 for the whole frame. Header bits 11..10, 8, 4 and 1..0 are ignored.
- R3: Header bits 7..5 hold the opcode: 3'b001 read wiper, 3'b010 write wiper, 3'b011 read data register, 3'b100 write data register, 3'b101 data register to wiper, 3'b110 wiper to data register, 3'b111 read status, 3'b000 no operation. Opcodes 101 and 110 need exactly 16 SCK rising edges and all others need exactly 32. A frame with any other count when chip select rises is discarded.
- R4: Write wiper loads the last ten bits of a 32-bit frame (MSB first) into `wiper_pos`. It does so only on the third `clk` edge after chip select rises; `wiper_pos` changes at no other time.
- R5: Write data register stores the last ten frame bits into the register picked by header bits 3..2. On the same edge it sets `save_busy`, which stays high for exactly `SAVE_CYCLES` clock cycles.
- R6: For read wiper and read data register, the 16-bit word {6'b0, value} is shifted out MSB first. The first bit appears after the 16th SCK falling edge and each following bit after the next falling edge. `spi_miso_oe` is high only during that data phase.
- R7: Read status shifts out a 16-bit word whose bit 0 is `save_busy` as seen at the 16th SCK falling edge; bits 15..1 are zero.
- R8: Opcode 101 copies the selected data register into `wiper_pos`. Opcode 110 copies `wiper_pos` into the selected data register and starts a save as in R5.
- R9: Opcodes 010, 100, 101 and 110 have no effect when they commit in a cycle where `save_busy` is high, and that includes its last cycle.
- R10: The bit counter is cleared while chip select is high, so a frame that follows a discarded one is decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap value the header address bit must match |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| wiper_pos | output | WIPER_W | Current wiper setting |
| save_busy | output | 1 | Save in progress |

## Verification
The commit of a state-changing command and the final cycle of the save countdown can fall on the same clock edge. Whether that command is dropped depends on busy as registered, not on its next value. The bench shifts a complete write while a save runs and keeps chip select low. It then raises chip select when its own countdown shows that the commit edge will meet the last busy cycle in one case and the first idle cycle in the other. The per-clock comparison of `save_busy` and `wiper_pos`, together with a later readback of the register, decides which of the two writes landed.

// File: rtl/spipot_pkg.sv
`timescale 1ns/1ps
package spipot_pkg;
  localparam int WORD_W   = 16;
  localparam int SEL_W    = 2;
  localparam int DR_COUNT = 1 << SEL_W;
  localparam int BIT_W    = 6;

  localparam logic [BIT_W-1:0] LEN_SHORT = BIT_W'(WORD_W);
  localparam logic [BIT_W-1:0] LEN_LONG  = BIT_W'(2 * WORD_W);
  localparam logic [BIT_W-1:0] BIT_MAX   = '1;

  typedef enum logic [2:0] {
    OP_NONE          = 3'b000,
    OP_RD_WIPER      = 3'b001,
    OP_WR_WIPER      = 3'b010,
    OP_RD_DREG       = 3'b011,
    OP_WR_DREG       = 3'b100,
    OP_DREG_TO_WIPER = 3'b101,
    OP_WIPER_TO_DREG = 3'b110,
    OP_RD_STATUS     = 3'b111
  } op_e;

  typedef struct packed {
    logic [3:0]       dev_id;
    logic [1:0]       rsv_a;
    logic             addr;
    logic             rw;
    op_e              op;
    logic             rsv_b;
    logic [SEL_W-1:0] sel;
    logic [1:0]       rsv_c;
  } hdr_t;

  function automatic logic op_is_short(op_e op);
    return (op == OP_DREG_TO_WIPER) || (op == OP_WIPER_TO_DREG);
  endfunction

  function automatic logic op_is_read(op_e op);
    return (op == OP_RD_WIPER) || (op == OP_RD_DREG) || (op == OP_RD_STATUS);
  endfunction
endpackage

// File: rtl/spipot_insync.sv
`timescale 1ns/1ps
module spipot_insync #(
  parameter int             W    = 3,
  parameter logic [W-1:0]   IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= IDLE[i];
        s2_q[i] <= IDLE[i];
        s3_q[i] <= IDLE[i];
      end else begin
        s1_q[i] <= d[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end
    assign lvl[i]  = s2_q[i];
    assign rise[i] = s2_q[i] & ~s3_q[i];
    assign fall[i] = ~s2_q[i] & s3_q[i];
  end
endmodule

// File: rtl/spipot_frame.sv
`timescale 1ns/1ps
module spipot_frame
  import spipot_pkg::*;
#(
  parameter int         WIPER_W = 10,
  parameter logic [3:0] DEV_ID  = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_sel,
  input  logic               cs_hi,
  input  logic               cs_rise,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               mosi,
  input  logic [WORD_W-1:0]  rd_word,
  output op_e                hdr_op,
  output logic [SEL_W-1:0]   hdr_sel,
  output logic               cmt_valid,
  output logic [WIPER_W-1:0] cmt_data,
  output logic               miso,
  output logic               miso_oe
);
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [WORD_W-1:0] rx_q, rx_n;
  logic [WORD_W-1:0] tx_q, tx_n;
  hdr_t              hdr_q, hdr_n;
  logic              miso_q, miso_n;
  logic              oe_q, oe_n;
  logic              hdr_ok;
  logic [BIT_W-1:0]  need_len;
  logic              upd;
  logic              hdr_unused;

  assign hdr_ok     = (hdr_q.dev_id == DEV_ID) && (hdr_q.addr == addr_sel);
  assign need_len   = op_is_short(hdr_q.op) ? LEN_SHORT : LEN_LONG;
  assign hdr_unused = ^{hdr_q.rsv_a, hdr_q.rw, hdr_q.rsv_b, hdr_q.rsv_c};
  assign upd        = cs_hi | sck_rise | sck_fall;

  always_comb begin
    bit_n  = bit_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    hdr_n  = hdr_q;
    miso_n = miso_q;
    oe_n   = oe_q;
    if (cs_hi) begin
      bit_n  = '0;
      oe_n   = 1'b0;
      miso_n = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_n = {rx_q[WORD_W-2:0], mosi};
        if (bit_q != BIT_MAX) bit_n = bit_q + BIT_W'(1);
        if (bit_q == LEN_SHORT - BIT_W'(1)) hdr_n = hdr_t'({rx_q[WORD_W-2:0], mosi});
      end
      if (sck_fall) begin
        if (bit_q == LEN_SHORT) begin
          oe_n   = hdr_ok && op_is_read(hdr_q.op);
          miso_n = rd_word[WORD_W-1];
          tx_n   = {rd_word[WORD_W-2:0], 1'b0};
        end else if (bit_q > LEN_SHORT && bit_q < LEN_LONG) begin
          miso_n = tx_q[WORD_W-1];
          tx_n   = {tx_q[WORD_W-2:0], 1'b0};
        end else if (bit_q >= LEN_LONG) begin
          oe_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      hdr_q  <= hdr_t'('0);
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (upd) begin
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      hdr_q  <= hdr_n;
      miso_q <= miso_n;
      oe_q   <= oe_n;
    end
  end

  assign cmt_valid = cs_rise && hdr_ok && (hdr_q.op != OP_NONE) && (bit_q == need_len);
  assign cmt_data  = rx_q[WIPER_W-1:0];
  assign hdr_op    = hdr_q.op;
  assign hdr_sel   = hdr_q.sel;
  assign miso      = miso_q;
  assign miso_oe   = oe_q;
endmodule

// File: rtl/spipot_regs.sv
`timescale 1ns/1ps
module spipot_regs
  import spipot_pkg::*;
#(
  parameter int                 WIPER_W     = 10,
  parameter int                 SAVE_CYCLES = 1000,
  parameter logic [WIPER_W-1:0] WIPER_INIT  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmt_valid,
  input  op_e                hdr_op,
  input  logic [SEL_W-1:0]   hdr_sel,
  input  logic [WIPER_W-1:0] cmt_data,
  output logic [WORD_W-1:0]  rd_word,
  output logic [WIPER_W-1:0] wiper_pos,
  output logic               save_busy
);
  localparam int             CNT_W    = $clog2(SAVE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SAVE_CYCLES);
  localparam int             PAD_W    = WORD_W - WIPER_W;

  logic [WIPER_W-1:0]  wiper_q, wiper_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [WIPER_W-1:0]  dr_q [DR_COUNT];
  logic [DR_COUNT-1:0] dr_we;
  logic [WIPER_W-1:0]  dr_wdata;
  logic                busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    wiper_n  = wiper_q;
    dr_we    = '0;
    dr_wdata = cmt_data;
    cnt_n    = busy ? cnt_q - CNT_W'(1) : cnt_q;
    if (cmt_valid && !busy) begin
      case (hdr_op)
        OP_WR_WIPER:      wiper_n = cmt_data;
        OP_DREG_TO_WIPER: wiper_n = dr_q[hdr_sel];
        OP_WR_DREG: begin
          dr_we[hdr_sel] = 1'b1;
          cnt_n          = CNT_LOAD;
        end
        OP_WIPER_TO_DREG: begin
          dr_we[hdr_sel] = 1'b1;
          dr_wdata       = wiper_q;
          cnt_n          = CNT_LOAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= WIPER_INIT;
      cnt_q   <= '0;
    end else begin
      wiper_q <= wiper_n;
      cnt_q   <= cnt_n;
    end
  end

  for (genvar i = 0; i < DR_COUNT; i++) begin : g_dreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dr_q[i] <= '0;
      else if (dr_we[i]) dr_q[i] <= dr_wdata;
    end
  end

  always_comb begin
    case (hdr_op)
      OP_RD_WIPER:  rd_word = {{PAD_W{1'b0}}, wiper_q};
      OP_RD_DREG:   rd_word = {{PAD_W{1'b0}}, dr_q[hdr_sel]};
      OP_RD_STATUS: rd_word = {{(WORD_W-1){1'b0}}, busy};
      default:      rd_word = '0;
    endcase
  end

  assign wiper_pos = wiper_q;
  assign save_busy = busy;
endmodule

// File: rtl/spipot_ctrl.sv
`timescale 1ns/1ps
module spipot_ctrl
  import spipot_pkg::*;
#(
  parameter int                 WIPER_W     = 10,
  parameter int                 SAVE_CYCLES = 1000,
  parameter logic [3:0]         DEV_ID      = 4'b0101,
  parameter logic [WIPER_W-1:0] WIPER_INIT  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_sel,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               spi_miso_oe,
  output logic [WIPER_W-1:0] wiper_pos,
  output logic               save_busy
);
  localparam int IN_W = 3;

  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic [IN_W-1:0]   in_lvl, in_rise, in_fall;
  logic              cs_hi, cs_rise, sck_rise, sck_fall, mosi_s;
  logic              sync_unused;
  op_e               hdr_op;
  logic [SEL_W-1:0]  hdr_sel;
  logic              cmt_valid;
  logic [WIPER_W-1:0] cmt_data;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  spipot_insync #(.W(IN_W), .IDLE(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d    ({spi_cs_n, spi_sck, spi_mosi}),
    .lvl  (in_lvl),
    .rise (in_rise),
    .fall (in_fall)
  );

  assign cs_hi       = in_lvl[2];
  assign cs_rise     = in_rise[2];
  assign sck_rise    = in_rise[1];
  assign sck_fall    = in_fall[1];
  assign mosi_s      = in_lvl[0];
  assign sync_unused = ^{in_fall[2], in_lvl[1], in_rise[0], in_fall[0]};

  spipot_frame #(.WIPER_W(WIPER_W), .DEV_ID(DEV_ID)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .addr_sel (addr_sel),
    .cs_hi    (cs_hi),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi     (mosi_s),
    .rd_word  (rd_word),
    .hdr_op   (hdr_op),
    .hdr_sel  (hdr_sel),
    .cmt_valid(cmt_valid),
    .cmt_data (cmt_data),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  spipot_regs #(.WIPER_W(WIPER_W), .SAVE_CYCLES(SAVE_CYCLES), .WIPER_INIT(WIPER_INIT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cmt_valid(cmt_valid),
    .hdr_op   (hdr_op),
    .hdr_sel  (hdr_sel),
    .cmt_data (cmt_data),
    .rd_word  (rd_word),
    .wiper_pos(wiper_pos),
    .save_busy(save_busy)
  );
endmodule

// File: rtl/spipot_ctrl_chk.sv
`timescale 1ns/1ps
module spipot_ctrl_chk #(
  parameter int WIPER_W     = 10,
  parameter int SAVE_CYCLES = 1000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_hi,
  input logic               cmt_valid,
  input logic               spi_miso_oe,
  input logic               save_busy,
  input logic [WIPER_W-1:0] wiper_pos
);
  localparam int LEN_W = $clog2(SAVE_CYCLES + 2);

  logic [LEN_W-1:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 busy_len_q <= '0;
    else if (!save_busy)        busy_len_q <= '0;
    else if (busy_len_q != '1)  busy_len_q <= busy_len_q + LEN_W'(1);
  end

  AST_OE_DROPS_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !spi_miso_oe); // R6

  AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    save_busy |-> (busy_len_q < LEN_W'(SAVE_CYCLES))); // R5

  AST_BUSY_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(save_busy) |-> (busy_len_q == LEN_W'(SAVE_CYCLES))); // R5

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_busy) |-> $past(cmt_valid)); // R5

  AST_WIPER_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid |=> $stable(wiper_pos)); // R4

  AST_WIPER_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    save_busy |=> $stable(wiper_pos)); // R9
endmodule

bind spipot_ctrl spipot_ctrl_chk #(.WIPER_W(WIPER_W), .SAVE_CYCLES(SAVE_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .cs_hi      (cs_hi),
  .cmt_valid  (cmt_valid),
  .spi_miso_oe(spi_miso_oe),
  .save_busy  (save_busy),
  .wiper_pos  (wiper_pos)
);

// File: tb/tb_spipot_ctrl.sv
`timescale 1ns/1ps
module tb_spipot_ctrl;
  import spipot_pkg::*;

  localparam int SAVE = 600;
  localparam int HALF = 6;
  localparam int WW   = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, addr_sel, sck, cs_n, mosi;
  logic          miso, miso_oe, save_busy;
  logic [WW-1:0] wiper_pos;

  spipot_ctrl #(.WIPER_W(WW), .SAVE_CYCLES(SAVE)) dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .wiper_pos(wiper_pos), .save_busy(save_busy)
  );

  int checks = 0, failures = 0;
  int m_wiper, m_cnt, pend;
  int m_dr[4];
  bit pend_ok, cmp_en, oe_seen, busy_now, load;
  op_e pend_op;
  int pend_sel, pend_data;
  logic [15:0] rx;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: commit lands on the third clk edge after cs_n rises
  always @(posedge clk) begin
    if (!rst_n) begin
      m_wiper = 0; m_cnt = 0; pend = 0;
      for (int i = 0; i < 4; i++) m_dr[i] = 0;
    end else begin
      busy_now = (m_cnt != 0);
      load = 1'b0;
      if (pend == 1 && pend_ok && !busy_now) begin
        case (pend_op)
          OP_WR_WIPER:      m_wiper = pend_data;
          OP_DREG_TO_WIPER: m_wiper = m_dr[pend_sel];
          OP_WR_DREG:       begin m_dr[pend_sel] = pend_data; load = 1'b1; end
          OP_WIPER_TO_DREG: begin m_dr[pend_sel] = m_wiper; load = 1'b1; end
          default: ;
        endcase
      end
      if (load) m_cnt = SAVE;
      else if (busy_now) m_cnt = m_cnt - 1;
      if (pend != 0) pend = pend - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(wiper_pos == m_wiper[WW-1:0], "R4 per-clock wiper", int'(wiper_pos), m_wiper);
      check(save_busy == (m_cnt != 0), "R5 per-clock busy", int'(save_busy), int'(m_cnt != 0));
    end
    if (miso_oe) oe_seen = 1'b1;
  end

  function automatic logic [31:0] mk(input logic [3:0] id, input logic a, input op_e op,
                                     input int sel, input int data);
    logic [1:0] s;
    logic [9:0] d;
    s = sel[1:0];
    d = data[9:0];
    return {id, 2'b00, a, 1'b0, op, 1'b0, s, 2'b00, 6'b000000, d};
  endfunction

  task automatic shift(input logic [31:0] w, input int n);
    @(negedge clk);
    oe_seen = 1'b0;
    rx = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 32) ? w[31-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 32) rx[31-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close(input bit ok, input op_e op, input int sel, input int data);
    cs_n = 1'b1;
    pend_ok = ok; pend_op = op; pend_sel = sel; pend_data = data;
    pend = 3;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input bit ok, input op_e op, input int sel, input int data, input int n);
    shift(mk(4'b0101, 1'b1, op, sel, data), n);
    close(ok, op, sel, data);
  endtask

  task automatic wait_idle();
    while (m_cnt != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_sel = 1'b1; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0; cmp_en = 1'b0;
    pend_ok = 1'b0; pend_op = OP_NONE; pend_sel = 0; pend_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(wiper_pos == 0, "R1 reset wiper", int'(wiper_pos), 0);
    check(save_busy == 0, "R1 reset busy", int'(save_busy), 0);
    check(miso_oe == 0, "R1 reset oe", int'(miso_oe), 0);
    cmp_en = 1'b1;
    frame(1, OP_RD_DREG, 1, 0, 32);
    check(rx == 16'h0000, "R1 reset data register", int'(rx), 0);

    // write and read back the wiper
    frame(1, OP_WR_WIPER, 0, 'h2A5, 32);
    frame(1, OP_RD_WIPER, 0, 0, 32);
    check(rx == 16'h02A5, "R6 read wiper word", int'(rx), 'h2A5);
    check(oe_seen == 1, "R6 oe during read", int'(oe_seen), 1);
    frame(1, OP_WR_WIPER, 0, 'h2A5, 32);
    check(oe_seen == 0, "R6 oe stays low on write", int'(oe_seen), 0);

    // header mismatch: wrong code, then wrong address bit
    shift(mk(4'b0110, 1'b1, OP_WR_WIPER, 0, 'h111), 32);
    close(0, OP_WR_WIPER, 0, 'h111);
    check(wiper_pos == 10'h2A5, "R2 wrong code ignored", int'(wiper_pos), 'h2A5);
    check(oe_seen == 0, "R2 wrong code no drive", int'(oe_seen), 0);
    shift(mk(4'b0101, 1'b0, OP_RD_WIPER, 0, 0), 32);
    close(0, OP_RD_WIPER, 0, 0);
    check(oe_seen == 0, "R2 wrong address no drive", int'(oe_seen), 0);

    // data register write starts a save; status polled during and after
    frame(1, OP_WR_DREG, 2, 'h155, 32);
    check(save_busy == 1, "R5 save started", int'(save_busy), 1);
    frame(1, OP_RD_STATUS, 0, 0, 32);
    check(rx == 16'h0001, "R7 status while busy", int'(rx), 1);
    wait_idle();
    frame(1, OP_RD_STATUS, 0, 0, 32);
    check(rx == 16'h0000, "R7 status when idle", int'(rx), 0);
    frame(1, OP_RD_DREG, 2, 0, 32);
    check(rx == 16'h0155, "R5 data register 2 stored", int'(rx), 'h155);

    // writes during a save are dropped
    frame(1, OP_WR_DREG, 3, 'h0F0, 32);
    frame(1, OP_WR_WIPER, 0, 'h001, 32);
    check(wiper_pos == 10'h2A5, "R9 wiper write while busy ignored", int'(wiper_pos), 'h2A5);
    wait_idle();
    frame(1, OP_RD_DREG, 3, 0, 32);
    check(rx == 16'h00F0, "R5 data register 3 stored", int'(rx), 'h0F0);

    // transfers
    frame(1, OP_DREG_TO_WIPER, 2, 0, 16);
    check(wiper_pos == 10'h155, "R8 register to wiper", int'(wiper_pos), 'h155);
    frame(1, OP_WR_WIPER, 0, 'h3FF, 32);
    frame(1, OP_WIPER_TO_DREG, 1, 0, 16);
    check(save_busy == 1, "R8 wiper to register starts save", int'(save_busy), 1);
    wait_idle();
    frame(1, OP_RD_DREG, 1, 0, 32);
    check(rx == 16'h03FF, "R8 wiper copied to register 1", int'(rx), 'h3FF);

    // wrong lengths are discarded; the next frame decodes cleanly
    frame(0, OP_WR_WIPER, 0, 'h0AA, 20);
    check(wiper_pos == 10'h3FF, "R3 short frame discarded", int'(wiper_pos), 'h3FF);
    frame(0, OP_WR_WIPER, 0, 'h0AA, 33);
    check(wiper_pos == 10'h3FF, "R3 long frame discarded", int'(wiper_pos), 'h3FF);
    frame(0, OP_DREG_TO_WIPER, 3, 0, 32);
    check(wiper_pos == 10'h3FF, "R3 transfer with 32 bits discarded", int'(wiper_pos), 'h3FF);
    frame(1, OP_WR_WIPER, 0, 'h0AA, 32);
    check(wiper_pos == 10'h0AA, "R10 frame after abort decoded", int'(wiper_pos), 'h0AA);

    // commit against the end of a save
    frame(1, OP_WR_DREG, 0, 'h111, 32);
    shift(mk(4'b0101, 1'b1, OP_WR_DREG, 0, 'h222), 32);
    while (m_cnt != 2) @(negedge clk);
    close(1, OP_WR_DREG, 0, 'h222);
    check(save_busy == 1, "R9 commit on first idle cycle accepted", int'(save_busy), 1);
    shift(mk(4'b0101, 1'b1, OP_WR_DREG, 0, 'h333), 32);
    while (m_cnt != 3) @(negedge clk);
    close(1, OP_WR_DREG, 0, 'h333);
    check(save_busy == 0, "R9 commit on last busy cycle no restart", int'(save_busy), 0);
    wait_idle();
    frame(1, OP_RD_DREG, 0, 0, 32);
    check(rx == 16'h0222, "R9 register 0 holds accepted value", int'(rx), 'h222);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule